// File: doc/BRIEF.md
# Register-List Block Store Sequencer

This block turns one multi-register store command into a run of single-word memory writes. A command carries a 16-bit selection mask, a base address, a two-bit walk mode, a writeback request, a user-bank select, the index of the base register and an alignment-check enable. The sequencer visits the selected registers from the lowest index to the highest. For each one it reads the value through a read port and issues a 32-bit write on a valid/ready channel. Successive writes go to word addresses that rise by four.

When the command ends, a one-cycle completion pulse carries the status. That status is a normal end with an optional updated base value, an empty-mask error, an alignment fault, or an abort. An abort is signalled by the memory side on any accepted write. The block does not decode instructions and does not hold the register file. It only generates the addresses, orders the reads and reports the outcome.

Top module: `bsq_store_seq`

## Requirements
- R1: Mask bit i selects register i. Writes are issued in increasing register index, one per selected register. Each write goes to the address of the previous write plus 4, and `wr_data` equals the `rd_data` returned for the register named on `rd_idx`.
- R2: The first write address depends on `cmd_mode`, where base is `cmd_base` and n is the number of selected registers. Code 00 starts at base. Code 01 starts at base+4. Code 10 starts at base−4n+4. Code 11 starts at base−4n. The last write therefore lands at the first address plus 4n−4.
- R3: A command whose mask is all zero issues no write. It ends with `done` and `err_empty` high.
- R4: Bits [1:0] of every write address are zero, whatever the low bits of the base.
- R5: When `cmd_align_chk` is high and bits [1:0] of `cmd_base` are not both zero, no write is issued. The command ends with `done` and `err_align` high. An empty mask takes precedence over this fault.
- R6: On normal completion, `wb_value` is base+4n for codes 00 and 01, and base−4n for codes 10 and 11. `wb_valid` is high in the `done` cycle only when writeback was requested and user-bank mode is off.
- R7: `wr_undef` is high on the write of the base register only in one case. Writeback is requested, user-bank mode is off, the base register is selected and it is not the lowest selected register. It is low on every other write.
- R8: With `cmd_user` high, `rd_user` is high during every write, so the stored values come from the user bank. The base still comes from `cmd_base`, and writeback is never reported.
- R9: A write accepted with `wr_abort` high is the last one. In the next cycle `done` and `aborted` are high and `wb_valid` is low.
- R10: While `wr_valid` is high and `wr_ready` is low, the write address, data, register index and undefined flag hold their values.
- R11: `cmd_ready` is high exactly when the sequencer is idle. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. The first write appears on the next cycle, and `done` follows the cycle after the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_mask | input | 16 | Register selection mask, bit i for register i |
| cmd_base | input | 32 | Base address |
| cmd_mode | input | 2 | Walk mode: 00 up-after, 01 up-before, 10 down-after, 11 down-before |
| cmd_wback | input | 1 | Writeback of the updated base requested |
| cmd_user | input | 1 | Store user-bank register values |
| cmd_base_idx | input | 4 | Index of the register that holds the base |
| cmd_align_chk | input | 1 | Fault on a base that is not word aligned |
| rd_idx | output | 4 | Register index being read |
| rd_user | output | 1 | Read from the user bank |
| rd_data | input | 32 | Register value for `rd_idx`, same cycle |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Word-aligned write address |
| wr_data | output | 32 | Write data |
| wr_undef | output | 1 | Stored value is undefined (base register case) |
| wr_abort | input | 1 | Abort response, meaningful with `wr_ready` |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | `wb_value` should be written back to the base register |
| wb_value | output | 32 | Updated base value |
| err_empty | output | 1 | Command had an empty mask |
| err_align | output | 1 | Command had a misaligned base with checking on |
| aborted | output | 1 | Command ended by an abort response |

## Verification
The assertions rely on three properties of the environment. The register file answers `rd_idx` and `rd_user` within the same cycle. `wr_abort` is only looked at on a cycle where `wr_ready` is high. A new command is only taken while the sequencer is idle. The bench models the register file as a pure function of index and bank. It raises `wr_abort` only together with `wr_ready`, and it presents each command for a single cycle from the idle state. Across the sweep, mask shapes, walk modes, base values (including ones that wrap past zero) and ready stalls are combined. Expected addresses, data and status are worked out arithmetically from the command.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   typedef enum logic [1:0] {
      WALK_UP_AFTER  = 2'b00,
      WALK_UP_BEFORE = 2'b01,
      WALK_DN_AFTER  = 2'b10,
      WALK_DN_BEFORE = 2'b11
   } walk_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_FIN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/bsq_lowbit.sv
module bsq_lowbit #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx
);
   logic [N-1:0] iso;

   assign iso = vec & (~vec + N'(1));

   for (genvar b = 0; b < IW; b++) begin : g_bit
      logic [N-1:0] col;
      for (genvar j = 0; j < N; j++) begin : g_col
         assign col[j] = ((j >> b) & 1) == 1;
      end
      assign idx[b] = |(iso & col);
   end
endmodule

// File: rtl/bsq_popcnt.sv
module bsq_popcnt #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] count
);
   always_comb begin
      count = '0;
      for (int i = 0; i < N; i++) begin
         count = count + CW'(vec[i]);
      end
   end
endmodule

// File: rtl/bsq_addr_plan.sv
module bsq_addr_plan
   import bsq_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 5
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] count,
   input  walk_mode_e    mode,
   output logic [AW-1:0] first_addr,
   output logic [AW-1:0] final_base
);
   logic [AW-1:0] span;

   assign span = AW'(count) << 2;

   always_comb begin
      unique case (mode)
         WALK_UP_AFTER:  first_addr = base;
         WALK_UP_BEFORE: first_addr = base + AW'(4);
         WALK_DN_AFTER:  first_addr = base - span + AW'(4);
         default:        first_addr = base - span;
      endcase
      final_base = mode[1] ? (base - span) : (base + span);
   end
endmodule

// File: rtl/bsq_store_seq.sv
module bsq_store_seq
   import bsq_pkg::*;
#(
   parameter int NREG = 16,
   parameter int AW   = 32,
   parameter int DW   = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   output logic                     cmd_ready,
   input  logic [NREG-1:0]          cmd_mask,
   input  logic [AW-1:0]            cmd_base,
   input  logic [1:0]               cmd_mode,
   input  logic                     cmd_wback,
   input  logic                     cmd_user,
   input  logic [$clog2(NREG)-1:0]  cmd_base_idx,
   input  logic                     cmd_align_chk,
   output logic [$clog2(NREG)-1:0]  rd_idx,
   output logic                     rd_user,
   input  logic [DW-1:0]            rd_data,
   output logic                     wr_valid,
   input  logic                     wr_ready,
   output logic [AW-1:0]            wr_addr,
   output logic [DW-1:0]            wr_data,
   output logic                     wr_undef,
   input  logic                     wr_abort,
   output logic                     done,
   output logic                     wb_valid,
   output logic [AW-1:0]            wb_value,
   output logic                     err_empty,
   output logic                     err_align,
   output logic                     aborted
);
   localparam int IW = $clog2(NREG);
   localparam int CW = $clog2(NREG + 1);

   if (NREG < 2 || (1 << IW) != NREG) begin : g_bad_nreg
      $error("bsq_store_seq: NREG must be a power of two of at least 2");
   end
   if (AW < 3) begin : g_bad_aw
      $error("bsq_store_seq: AW must be at least 3");
   end
   if (DW < 1) begin : g_bad_dw
      $error("bsq_store_seq: DW must be positive");
   end

   seq_state_e     state_q;
   logic [NREG-1:0] rem_q;
   logic [AW-1:0]  addr_q;
   logic [AW-1:0]  wbv_q;
   logic           wbk_q;
   logic           user_q;
   logic           undef_en_q;
   logic [IW-1:0]  bidx_q;
   logic           st_wb_q;
   logic           st_empty_q;
   logic           st_align_q;
   logic           st_abort_q;

   logic [CW-1:0]  sel_count;
   logic [IW-1:0]  first_idx;
   logic [IW-1:0]  cur_idx;
   logic [AW-1:0]  plan_first;
   logic [AW-1:0]  plan_final;
   logic           fire;
   logic           beat_ok;
   logic           last_beat;
   logic           base_late;

   bsq_popcnt #(.N(NREG), .CW(CW)) u_count (
      .vec   (cmd_mask),
      .count (sel_count)
   );

   bsq_lowbit #(.N(NREG), .IW(IW)) u_first (
      .vec (cmd_mask),
      .idx (first_idx)
   );

   bsq_lowbit #(.N(NREG), .IW(IW)) u_cur (
      .vec (rem_q),
      .idx (cur_idx)
   );

   bsq_addr_plan #(.AW(AW), .CW(CW)) u_plan (
      .base       (cmd_base),
      .count      (sel_count),
      .mode       (walk_mode_e'(cmd_mode)),
      .first_addr (plan_first),
      .final_base (plan_final)
   );

   assign cmd_ready = (state_q == SQ_IDLE);
   assign fire      = cmd_valid && cmd_ready;
   assign wr_valid  = (state_q == SQ_RUN);
   assign beat_ok   = wr_valid && wr_ready && !wr_abort;
   assign last_beat = (rem_q & (rem_q - NREG'(1))) == '0;
   assign base_late = cmd_wback && !cmd_user && cmd_mask[cmd_base_idx]
                      && (cmd_base_idx != first_idx);

   assign rd_idx    = cur_idx;
   assign rd_user   = user_q;
   assign wr_addr   = addr_q;
   assign wr_data   = rd_data;
   assign wr_undef  = wr_valid && undef_en_q && (cur_idx == bidx_q);

   assign done      = (state_q == SQ_FIN);
   assign wb_valid  = done && st_wb_q;
   assign wb_value  = wbv_q;
   assign err_empty = done && st_empty_q;
   assign err_align = done && st_align_q;
   assign aborted   = done && st_abort_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         rem_q      <= '0;
         addr_q     <= '0;
         wbv_q      <= '0;
         wbk_q      <= 1'b0;
         user_q     <= 1'b0;
         undef_en_q <= 1'b0;
         bidx_q     <= '0;
         st_wb_q    <= 1'b0;
         st_empty_q <= 1'b0;
         st_align_q <= 1'b0;
         st_abort_q <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (fire) begin
                  st_wb_q    <= 1'b0;
                  st_empty_q <= 1'b0;
                  st_align_q <= 1'b0;
                  st_abort_q <= 1'b0;
                  user_q     <= cmd_user;
                  if (cmd_mask == '0) begin
                     st_empty_q <= 1'b1;
                     state_q    <= SQ_FIN;
                  end else if (cmd_align_chk && (cmd_base[1:0] != 2'b00)) begin
                     st_align_q <= 1'b1;
                     state_q    <= SQ_FIN;
                  end else begin
                     rem_q      <= cmd_mask;
                     addr_q     <= {plan_first[AW-1:2], 2'b00};
                     wbv_q      <= plan_final;
                     wbk_q      <= cmd_wback && !cmd_user;
                     undef_en_q <= base_late;
                     bidx_q     <= cmd_base_idx;
                     state_q    <= SQ_RUN;
                  end
               end
            end
            SQ_RUN: begin
               if (wr_ready && wr_abort) begin
                  st_abort_q <= 1'b1;
                  state_q    <= SQ_FIN;
               end else if (beat_ok) begin
                  rem_q  <= rem_q & (rem_q - NREG'(1));
                  addr_q <= addr_q + AW'(4);
                  if (last_beat) begin
                     st_wb_q <= wbk_q;
                     state_q <= SQ_FIN;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bsq_store_seq_chk.sv
module bsq_store_seq_chk #(
   parameter int NREG = 16,
   parameter int AW   = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cmd_ready,
   input logic [$clog2(NREG)-1:0] rd_idx,
   input logic                    rd_user,
   input logic                    wr_valid,
   input logic                    wr_ready,
   input logic [AW-1:0]           wr_addr,
   input logic                    wr_undef,
   input logic                    wr_abort,
   input logic                    done,
   input logic                    wb_valid,
   input logic                    err_empty,
   input logic                    err_align,
   input logic                    aborted
);
   p_word_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr[1:0] == 2'b00));

   p_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && !wr_abort) |=>
         (!wr_valid || ((wr_addr == $past(wr_addr) + AW'(4)) && (rd_idx > $past(rd_idx)))));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=>
         (wr_valid && $stable(wr_addr) && $stable(rd_idx) && $stable(wr_undef)));

   p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && wr_abort) |=> (done && aborted && !wb_valid));

   p_empty_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_empty) |-> !$past(wr_valid));

   p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !cmd_ready);

   p_user_nowb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !rd_user);

   p_status_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_empty, err_align, aborted, wb_valid}));
endmodule

bind bsq_store_seq bsq_store_seq_chk #(.NREG(NREG), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .rd_idx    (rd_idx),
   .rd_user   (rd_user),
   .wr_valid  (wr_valid),
   .wr_ready  (wr_ready),
   .wr_addr   (wr_addr),
   .wr_undef  (wr_undef),
   .wr_abort  (wr_abort),
   .done      (done),
   .wb_valid  (wb_valid),
   .err_empty (err_empty),
   .err_align (err_align),
   .aborted   (aborted)
);

// File: tb/bsq_store_seq_test.sv
module bsq_store_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [15:0] cmd_mask = '0;
   logic [31:0] cmd_base = '0;
   logic [1:0]  cmd_mode = '0;
   logic        cmd_wback = 1'b0;
   logic        cmd_user = 1'b0;
   logic [3:0]  cmd_base_idx = '0;
   logic        cmd_align_chk = 1'b0;
   logic [3:0]  rd_idx;
   logic        rd_user;
   logic [31:0] rd_data;
   logic        wr_valid;
   logic        wr_ready = 1'b0;
   logic [31:0] wr_addr;
   logic [31:0] wr_data;
   logic        wr_undef;
   logic        wr_abort = 1'b0;
   logic        done;
   logic        wb_valid;
   logic [31:0] wb_value;
   logic        err_empty;
   logic        err_align;
   logic        aborted;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] reg_val(input logic [3:0] idx, input logic usr);
      return (32'(idx) * 32'h0001_0101) ^ (usr ? 32'hEE00_0000 : 32'h1100_0000);
   endfunction

   assign rd_data = reg_val(rd_idx, rd_user);

   bsq_store_seq uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mask(cmd_mask),
      .cmd_base(cmd_base), .cmd_mode(cmd_mode), .cmd_wback(cmd_wback),
      .cmd_user(cmd_user), .cmd_base_idx(cmd_base_idx), .cmd_align_chk(cmd_align_chk),
      .rd_idx(rd_idx), .rd_user(rd_user), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_undef(wr_undef), .wr_abort(wr_abort),
      .done(done), .wb_valid(wb_valid), .wb_value(wb_value),
      .err_empty(err_empty), .err_align(err_align), .aborted(aborted)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL R11 watchdog actual=%0d expected<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic run_cmd(input logic [15:0] mask, input logic [31:0] base,
                          input logic [1:0] mode, input bit wb, input bit usr,
                          input logic [3:0] bidx, input bit achk,
                          input int abort_at, input bit stall);
      int order[16];
      int n = 0;
      int beat = 0;
      int guard = 0;
      int lowest = -1;
      bit err_e, err_a, ab_exp;
      logic [31:0] first, fin, span, ea;
      for (int i = 0; i < 16; i++) begin
         if (mask[i]) begin
            if (lowest < 0) lowest = i;
            order[n] = i;
            n++;
         end
      end
      span = 32'(n) * 32'd4;
      case (mode)
         2'b00: first = base;
         2'b01: first = base + 32'd4;
         2'b10: first = base - span + 32'd4;
         default: first = base - span;
      endcase
      fin   = mode[1] ? base - span : base + span;
      err_e = (n == 0);
      err_a = !err_e && achk && (base[1:0] != 2'b00);
      ab_exp = !err_e && !err_a && (abort_at >= 0) && (abort_at < n);

      @(negedge clk);
      cmd_mask = mask; cmd_base = base; cmd_mode = mode; cmd_wback = wb;
      cmd_user = usr; cmd_base_idx = bidx; cmd_align_chk = achk; cmd_valid = 1'b1;
      check(cmd_ready == 1'b1, "R11 ready when idle", 32'(cmd_ready), 32'd1);
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done && guard < 200) begin
         if (wr_valid) begin
            check(beat < n, "R1 beat count", 32'(beat), 32'(n));
            if (beat < n) begin
               ea = first + 32'(beat) * 32'd4;
               ea[1:0] = 2'b00;
               check(wr_addr == ea, "R2 R4 write address", wr_addr, ea);
               check(rd_idx == 4'(order[beat]), "R1 register order", 32'(rd_idx), 32'(order[beat]));
               check(wr_data == reg_val(4'(order[beat]), usr), "R1 R8 write data",
                     wr_data, reg_val(4'(order[beat]), usr));
               check(rd_user == usr, "R8 bank select", 32'(rd_user), 32'(usr));
               check(wr_undef == (wb && !usr && mask[bidx] && (int'(bidx) != lowest)
                                  && (order[beat] == int'(bidx))),
                     "R7 undefined flag", 32'(wr_undef), 32'(wb && !usr && order[beat] == int'(bidx)));
            end
            if (stall && (guard % 3 == 0)) begin
               wr_ready = 1'b0;
               wr_abort = 1'b0;
            end else begin
               wr_ready = 1'b1;
               wr_abort = (beat == abort_at);
               if (beat != abort_at) beat++;
            end
         end else begin
            wr_ready = 1'b0;
            wr_abort = 1'b0;
         end
         @(negedge clk);
         guard++;
      end
      wr_ready = 1'b0;
      wr_abort = 1'b0;
      check(done == 1'b1, "R11 completion pulse", 32'(done), 32'd1);
      check(wr_valid == 1'b0, "R11 no write at done", 32'(wr_valid), 32'd0);
      check(err_empty == err_e, "R3 empty error", 32'(err_empty), 32'(err_e));
      check(err_align == err_a, "R5 alignment fault", 32'(err_align), 32'(err_a));
      check(aborted == ab_exp, "R9 abort status", 32'(aborted), 32'(ab_exp));
      if (err_e || err_a) begin
         check(beat == 0, "R3 R5 no writes", 32'(beat), 32'd0);
         check(wb_valid == 1'b0, "R6 no writeback on error", 32'(wb_valid), 32'd0);
      end else if (ab_exp) begin
         check(beat == abort_at, "R9 writes before abort", 32'(beat), 32'(abort_at));
         check(wb_valid == 1'b0, "R9 writeback suppressed", 32'(wb_valid), 32'd0);
      end else begin
         check(beat == n, "R1 all registers written", 32'(beat), 32'(n));
         check(wb_valid == (wb && !usr), "R6 R8 writeback valid", 32'(wb_valid), 32'(wb && !usr));
         check(wb_value == fin, "R6 writeback value", wb_value, fin);
      end
      @(negedge clk);
      check(done == 1'b0, "R11 done is one cycle", 32'(done), 32'd0);
   endtask

   initial begin
      logic [15:0] masks[10];
      logic [31:0] bases[3];
      masks = '{16'h0001, 16'h8000, 16'hFFFF, 16'h0000, 16'hA5A5,
                16'h0110, 16'h7FFE, 16'h1248, 16'hC003, 16'h0F00};
      bases = '{32'h0000_1000, 32'h0000_0004, 32'h8000_0102};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1, "R11 reset idle", 32'(cmd_ready), 32'd1);
      check(wr_valid == 1'b0, "R11 reset no write", 32'(wr_valid), 32'd0);
      check(done == 1'b0, "R11 reset no done", 32'(done), 32'd0);

      // R1 R2 R4 R6 sweep of masks, walk modes and bases, with and without stalls (R10)
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 10; k++) begin
            for (int b = 0; b < 3; b++) begin
               run_cmd(masks[k], bases[b], 2'(m), 1'b1, 1'b0, 4'd9, 1'b0, -1, (k + b) % 2 == 1);
            end
         end
      end
      // R5 alignment fault, and empty mask precedence
      run_cmd(16'h00F0, 32'h0000_2001, 2'b00, 1'b1, 1'b0, 4'd0, 1'b1, -1, 1'b0);
      run_cmd(16'h0000, 32'h0000_2002, 2'b11, 1'b1, 1'b0, 4'd0, 1'b1, -1, 1'b0);
      run_cmd(16'h00F0, 32'h0000_2000, 2'b01, 1'b1, 1'b0, 4'd0, 1'b1, -1, 1'b0);
      // R7 base register lowest, not lowest, and without writeback
      run_cmd(16'h0A50, 32'h0000_3000, 2'b00, 1'b1, 1'b0, 4'd4, 1'b0, -1, 1'b0);
      run_cmd(16'h0A50, 32'h0000_3000, 2'b10, 1'b1, 1'b0, 4'd9, 1'b0, -1, 1'b0);
      run_cmd(16'h0A50, 32'h0000_3000, 2'b10, 1'b0, 1'b0, 4'd9, 1'b0, -1, 1'b0);
      // R8 user bank with writeback requested
      run_cmd(16'h6009, 32'h0000_4000, 2'b01, 1'b1, 1'b1, 4'd3, 1'b0, -1, 1'b1);
      run_cmd(16'hFFFF, 32'h0000_4000, 2'b11, 1'b1, 1'b1, 4'd15, 1'b0, -1, 1'b0);
      // R9 aborts on first, middle and last write
      run_cmd(16'h00FF, 32'h0000_5000, 2'b00, 1'b1, 1'b0, 4'd0, 1'b0, 0, 1'b0);
      run_cmd(16'h00FF, 32'h0000_5000, 2'b11, 1'b1, 1'b0, 4'd0, 1'b0, 4, 1'b1);
      run_cmd(16'h00FF, 32'h0000_5000, 2'b01, 1'b1, 1'b0, 4'd0, 1'b0, 7, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule